// File: doc/BRIEF.md
# Guarded Interrupt Vector Placement Register

This block is an eight-bit control register that decides where the interrupt vector table lives in program memory. It holds a placement bit. When the bit is clear, the table starts at word address zero. When it is set, the table starts at the base of the boot section, and that base is supplied from outside the block. Software can change the placement bit only through a two-step unlock. First it sets an arming bit. Then, within a short countdown window, it writes the new placement while writing zero to the arming bit.

While the unlock is in progress, the block raises an interrupt-suppress output. This output is separate from, and never touches, the processor's global interrupt-enable flag. The suppression lasts through the window. After a placement write, it lasts until the instruction that follows that write has retired.

Two lock flags add a further, permanent suppression. One applies while code runs from the region that does not hold the vector table. The upper six bits of the byte are plain read/write storage for other controls.

Top module: `ivs_ctrl`

## Requirements
- R1: `vec_base` is zero while the placement bit (bit 1) is 0, and equals `boot_base` while it is 1.
- R2: After reset, every bit of `rd_data` is 0. Bits 7 to 2 take the written value on every write. `rd_data` shows the arming bit (bit 0) in its live state.
- R3: The placement bit takes `wr_data[1]` only on a write with `wr_data[0]`=0 while the arming bit reads 1. A write that sets the arming bit, or a write made while the arming bit reads 0, leaves the placement bit unchanged.
- R4: A write with `wr_data[0]`=1 makes the arming bit read 1 for exactly `WIN` cycles (4 by default), after which it reads 0. A placement write clears it in the next cycle.
- R5: `irq_block` is 1 in the cycle of a write with `wr_data[0]`=1, and in every cycle in which the arming bit reads 1.
- R6: After a placement write, `irq_block` stays 1 up to and including the next cycle with `retire`=1. It falls in the cycle after that.
- R7: With the placement bit 1, `lock_boot`=1 and `exec_boot`=0, `irq_block` is 1.
- R8: With the placement bit 0, `lock_app`=1 and `exec_boot`=1, `irq_block` is 1. Neither lock suppresses interrupts when the running region holds the vectors.
- R9: Writing 1 to the arming bit while it already reads 1 restarts the countdown, so the bit reads 1 for `WIN` cycles after the latest such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| retire | input | 1 | One-cycle pulse when an instruction completes |
| exec_boot | input | 1 | 1 while code executes from the boot section |
| boot_base | input | AW | Word address of the boot section start |
| lock_boot | input | 1 | Boot-region lock flag |
| lock_app | input | 1 | Application-region lock flag |
| vec_base | output | AW | Base address of the active vector table |
| irq_block | output | 1 | Interrupt suppress request |
| rd_data | output | 8 | Register readback |

## Verification
The hardest cases to reach are at the edges of the countdown window. One is a placement write that lands in the last open cycle. Another is a re-arm that lands midway, after which the bit must stay set past the point where the first window would have expired. The stimulus reaches both by counting cycles exactly from the arming write, using per-cycle steps with hand-computed readback. The retire-gated release of suppression is driven by holding `retire` low for a cycle after the placement write and then pulsing it.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
    // Bit positions inside the control byte (software decodes these)
    localparam int ARM_BIT = 0;
    localparam int SEL_BIT = 1;
    localparam int MISC_W  = 6;

    // Stored part of the byte that the top register owns
    typedef struct packed {
        logic [MISC_W-1:0] misc;
        logic              sel;
    } ctl_state_t;
endpackage

// File: rtl/ivs_window.sv
// Arming bit, countdown and post-write hold
module ivs_window #(
    parameter int WIN = 4,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,      // write with arming bit = 1
    input  logic sel_wr,   // accepted placement write
    input  logic retire,
    output logic open,
    output logic hold
);
    typedef struct packed {
        logic          open;
        logic [CW-1:0] cnt;
        logic          hold;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d.open = 1'b1;
            st_d.cnt  = CW'(WIN);
        end else if (sel_wr) begin
            st_d.open = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.open) begin
            if (st_q.cnt == CW'(1)) begin
                st_d.open = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end

        if (sel_wr)
            st_d.hold = 1'b1;
        else if (st_q.hold && retire)
            st_d.hold = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = st_q.open;
    assign hold = st_q.hold;

    // R4 / R9: every opening of the window starts with a full count
    p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> st_q.cnt == CW'(WIN));

    // R4: placement write closes the window in the next cycle
    p_close_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !arm) |=> !st_q.open);

    // R6: hold releases after the retire pulse
    p_hold_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && retire && !sel_wr) |=> !st_q.hold);
endmodule

// File: rtl/ivs_lock.sv
// Region-lock suppression
module ivs_lock (
    input  logic sel,
    input  logic exec_boot,
    input  logic lock_boot,
    input  logic lock_app,
    output logic lock_block
);
    logic boot_side, app_side;

    always_comb begin
        boot_side  = sel  && lock_boot && !exec_boot;
        app_side   = !sel && lock_app  &&  exec_boot;
        lock_block = boot_side || app_side;
    end

    // R7 / R8: a lock never blocks code running in the vector-holding region
    always_comb begin
        p_region_match_r8: assert (!(lock_block && (sel == exec_boot)));
    end
endmodule

// File: rtl/ivs_ctrl.sv
module ivs_ctrl #(
    parameter int AW  = 16,
    parameter int WIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          retire,
    input  logic          exec_boot,
    input  logic [AW-1:0] boot_base,
    input  logic          lock_boot,
    input  logic          lock_app,
    output logic [AW-1:0] vec_base,
    output logic          irq_block,
    output logic [7:0]    rd_data
);
    import ivs_pkg::*;

    ctl_state_t reg_d, reg_q;
    logic arm, sel_wr, open, hold, lock_block;

    always_comb begin
        arm    = wr_en &&  wr_data[ARM_BIT];
        sel_wr = wr_en && !wr_data[ARM_BIT] && open;
        reg_d  = reg_q;
        if (wr_en)  reg_d.misc = wr_data[7:2];
        if (sel_wr) reg_d.sel  = wr_data[SEL_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    ivs_window #(.WIN(WIN)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .sel_wr (sel_wr),
        .retire (retire),
        .open   (open),
        .hold   (hold)
    );

    ivs_lock u_lock (
        .sel        (reg_q.sel),
        .exec_boot  (exec_boot),
        .lock_boot  (lock_boot),
        .lock_app   (lock_app),
        .lock_block (lock_block)
    );

    assign rd_data   = {reg_q.misc, reg_q.sel, open};
    assign vec_base  = reg_q.sel ? boot_base : '0;
    assign irq_block = arm || open || hold || lock_block;

    // R3: placement bit moves only after an in-window write with arming bit 0
    p_sel_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q.sel) |-> $past(wr_en && !wr_data[ARM_BIT] && open));

    // R5: arming write is itself suppressed
    p_block_on_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ARM_BIT]) |-> irq_block);

    // R6: hold always shows on the output
    p_hold_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> irq_block);

    // R1: application placement gives base zero
    p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[SEL_BIT] |-> vec_base == '0);
endmodule

// File: tb/tb_ivs_ctrl.sv
module tb_ivs_ctrl;
    localparam int AW = 16;
    localparam logic [AW-1:0] BOOT = 16'hF000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          retire = 1'b0;
    logic          exec_boot = 1'b0;
    logic [AW-1:0] boot_base = BOOT;
    logic          lock_boot = 1'b0;
    logic          lock_app = 1'b0;
    logic [AW-1:0] vec_base;
    logic          irq_block;
    logic [7:0]    rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic       blk;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    ivs_ctrl #(.AW(AW), .WIN(4)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .retire(retire), .exec_boot(exec_boot), .boot_base(boot_base),
        .lock_boot(lock_boot), .lock_app(lock_app),
        .vec_base(vec_base), .irq_block(irq_block), .rd_data(rd_data)
    );

    // Driver: one cycle of stimulus plus the outputs expected in that cycle
    task automatic step(input logic w, input logic [7:0] d, input logic r,
                        input logic ex, input logic la, input logic lb,
                        input logic [7:0] e_rd, input logic e_blk, input string req);
        exp_t it;
        @(negedge clk);
        wr_en = w; wr_data = d; retire = r;
        exec_boot = ex; lock_app = la; lock_boot = lb;
        it.rd = e_rd; it.blk = e_blk; it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [7:0] e_rd, input logic e_blk, input string req);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, e_rd, e_blk, req);
    endtask

    // Monitor: compares just after the driver has applied the cycle
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            exp_t it;
            logic [AW-1:0] e_base;
            it = sb.pop_front();
            e_base = it.rd[1] ? BOOT : '0;
            checks += 3;
            if (rd_data !== it.rd) begin
                failures++;
                $display("FAIL %s rd_data actual %h expected %h", it.req, rd_data, it.rd);
            end
            if (irq_block !== it.blk) begin
                failures++;
                $display("FAIL %s irq_block actual %b expected %b", it.req, irq_block, it.blk);
            end
            if (vec_base !== e_base) begin
                failures++;
                $display("FAIL R1 vec_base actual %h expected %h", vec_base, e_base);
            end
        end
    end

    initial begin
        // R2 reset state
        idle(8'h00, 1'b0, "R2");
        rst_n = 1'b1;

        // R2 plain storage of bits 7..2
        step(1, 8'hA4, 0, 0, 0, 0, 8'h00, 0, "R2");
        idle(8'hA4, 0, "R2");
        // R3 placement write with window closed is ignored
        step(1, 8'hA6, 0, 0, 0, 0, 8'hA4, 0, "R3");
        idle(8'hA4, 0, "R3");

        // Unlock then set placement; R5 and R6 suppression
        step(1, 8'hA5, 0, 0, 0, 0, 8'hA4, 1, "R5");
        idle(8'hA5, 1, "R5");
        step(1, 8'hA6, 0, 0, 0, 0, 8'hA5, 1, "R3");
        idle(8'hA6, 1, "R6");                                   // R4 arm bit cleared at once
        step(0, 8'h00, 1, 0, 0, 0, 8'hA6, 1, "R6");
        idle(8'hA6, 0, "R6");

        // R4 timeout; arming write keeps placement (R3)
        step(1, 8'hA7, 0, 0, 0, 0, 8'hA6, 1, "R5");
        for (int i = 0; i < 4; i++) idle(8'hA7, 1, "R4");
        idle(8'hA6, 0, "R4");
        // R3 late placement write after expiry
        step(1, 8'hA4, 0, 0, 0, 0, 8'hA6, 0, "R3");
        idle(8'hA6, 0, "R3");

        // R9 restart of the countdown; arming write with bit1=0 keeps sel (R3)
        step(1, 8'hA5, 0, 0, 0, 0, 8'hA6, 1, "R3");
        idle(8'hA7, 1, "R3");
        idle(8'hA7, 1, "R9");
        step(1, 8'hA5, 0, 0, 0, 0, 8'hA7, 1, "R9");
        for (int i = 0; i < 4; i++) idle(8'hA7, 1, "R9");
        idle(8'hA6, 0, "R9");

        // R3 / R4 placement write in the last open cycle
        step(1, 8'hA5, 0, 0, 0, 0, 8'hA6, 1, "R5");
        for (int i = 0; i < 3; i++) idle(8'hA7, 1, "R4");
        step(1, 8'hA4, 0, 0, 0, 0, 8'hA7, 1, "R3");
        step(0, 8'h00, 1, 0, 0, 0, 8'hA4, 1, "R6");
        idle(8'hA4, 0, "R6");

        // R8 application lock, placement 0
        step(0, 8'h00, 0, 1, 1, 0, 8'hA4, 1, "R8");
        step(0, 8'h00, 0, 0, 1, 0, 8'hA4, 0, "R8");
        step(0, 8'h00, 0, 0, 0, 1, 8'hA4, 0, "R7");

        // Move vectors to boot, then R7
        step(1, 8'hA5, 0, 0, 0, 0, 8'hA4, 1, "R5");
        step(1, 8'hA6, 0, 0, 0, 0, 8'hA5, 1, "R3");
        step(0, 8'h00, 1, 0, 0, 0, 8'hA6, 1, "R6");
        idle(8'hA6, 0, "R6");
        step(0, 8'h00, 0, 0, 0, 1, 8'hA6, 1, "R7");
        step(0, 8'h00, 0, 1, 0, 1, 8'hA6, 0, "R7");
        step(0, 8'h00, 0, 1, 1, 0, 8'hA6, 0, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule